// File: doc/BRIEF.md
# Dual-Map Two-Wire Memory Target

This block is the management-side serial target of a pluggable optical module. A host drives the clock line and shares an open-drain data line with the block. The block answers two 7-bit device addresses. Each address opens its own 256-byte map of 8-bit words. One map holds identification bytes and the other holds diagnostic values and flags. Both lines are brought into the system clock domain through a short synchronizer, and every protocol event is decoded from their edges.

A write transaction carries the device address, then one byte that sets the word pointer, then any number of data bytes. Each map keeps its own pointer. The pointer moves forward by one after every byte and wraps from 255 to 0. A read either continues from the pointer of the addressed map or, after a pointer-setting write and a repeated START, reads from a chosen location. Protected bytes still receive an ACK for a write, but their stored value does not change. The lower 96 bytes of the diagnostic map are always protected. The whole identification map becomes protected while the lock input is high.

Top module: `dual_map_i2c_target`

## Requirements
- R1: After reset the block does not drive SDA (`sda_oe_o` = 0), and both word pointers are 0.
- R2: Device byte 0xA0/0xA1 (7-bit 0x50) selects the identification map and 0xA2/0xA3 (7-bit 0x51) selects the diagnostic map. Both receive an ACK, and the two maps hold separate contents.
- R3: Any other device address receives a NACK. SDA stays released for the rest of that transaction, up to the next START or STOP.
- R4: In a write, the block ACKs the word-address byte and every data byte, and stores each data byte at the pointer of the addressed map.
- R5: The pointer advances by one after every byte written or read, and it wraps from 255 to 0.
- R6: In the diagnostic map, a write to bytes 0 to 95 is ACKed but leaves the byte unchanged. Bytes 96 to 255 are writable.
- R7: While `lock_i` is 1, a write to the identification map is ACKed but leaves every byte unchanged. While `lock_i` is 0, the map is writable.
- R8: A read with no preceding word address starts at the current pointer of the addressed map. The pointer of the other map is not affected.
- R9: A write of the word address followed by a repeated START and a read device byte returns data starting at that word address.
- R10: Read data goes out MSB first. `sda_oe_o` changes only while SCL is low. After a host NACK, the block keeps SDA released until a STOP or a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Resolved level of the shared data line |
| lock_i | input | 1 | 1 = identification map is write-protected |
| sda_oe_o | output | 1 | 1 = pull the data line low |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, device addresses 0x50 and 0x51, and the diagnostic protection boundary at 96. With these values the bench can reach the 255-to-0 pointer wrap in a short burst, and it can write across the boundary between bytes 95 and 96. The serial clock has a quarter period of six system clocks. This leaves room for the synchronizer delay, so every SDA change the block makes can be checked against the raw SCL level.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned MAPS   = 2;
    localparam logic        MAP_ID   = 1'b0;
    localparam logic        MAP_DIAG = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_HACK,
        ST_RD_NEXT,
        ST_WAIT
    } state_t;

    typedef struct packed {
        logic [6:0] dev;
        logic       rd;
    } dev_byte_t;

    // Returns 1 when a write to this map location must be dropped.
    function automatic logic wr_blocked(logic sel, logic [WORD_W-1:0] a,
                                        logic lock, int unsigned prot_end);
        return (sel == MAP_DIAG) ? (32'(a) < prot_end) : lock;
    endfunction

endpackage

// File: rtl/two_wire_sync.sv
module two_wire_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/map_mem.sv
module map_mem #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dual_map_i2c_target.sv
module dual_map_i2c_target
    import twm_pkg::*;
#(
    parameter logic [6:0]  ID_DEV        = 7'h50,
    parameter logic [6:0]  DIAG_DEV      = 7'h51,
    parameter int unsigned DIAG_PROT_END = 96,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic lock_i,
    output logic sda_oe_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    state_t              state;
    logic [2:0]          bit_cnt;
    logic [7:0]          shreg;
    logic                ack_on;
    logic                sel;
    logic                is_rd;
    logic                sda_oe;
    logic [WORD_W-1:0]   ptr [MAPS];
    logic [MAPS-1:0]     we_vec;
    logic [WORD_W-1:0]   wr_addr;
    logic [7:0]          wr_data;
    logic [7:0]          rd_data [MAPS];
    logic [7:0]          rx_byte;
    logic [7:0]          cur_rd;
    dev_byte_t           dev_b;

    two_wire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rx_byte = {shreg[6:0], sda_s};
    assign dev_b   = dev_byte_t'(rx_byte);
    assign cur_rd  = rd_data[sel];
    assign wr_addr = ptr[sel];
    assign wr_data = rx_byte;

    always_comb begin
        we_vec = '0;
        if (state == ST_WDATA && scl_rise && bit_cnt == 3'd7 && !start_det && !stop_det
            && !wr_blocked(sel, ptr[sel], lock_i, DIAG_PROT_END))
            we_vec[sel] = 1'b1;
    end

    for (genvar g = 0; g < MAPS; g++) begin : g_map
        map_mem #(.AW(WORD_W), .DW(8)) u_map (
            .clk   (clk),
            .rst   (rst),
            .we    (we_vec[g]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (ptr[g]),
            .rdata (rd_data[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ack_on  <= 1'b0;
            sel     <= MAP_ID;
            is_rd   <= 1'b0;
            sda_oe  <= 1'b0;
            for (int m = 0; m < MAPS; m++) ptr[m] <= '0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            ack_on  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            ack_on <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: if (scl_rise) begin
                    shreg   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        is_rd <= dev_b.rd;
                        if (dev_b.dev == ID_DEV) begin
                            sel   <= MAP_ID;
                            state <= ST_ADDR_ACK;
                        end else if (dev_b.dev == DIAG_DEV) begin
                            sel   <= MAP_DIAG;
                            state <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WORD_ACK, ST_WDATA_ACK: if (scl_fall) begin
                    if (!ack_on) begin
                        ack_on <= 1'b1;
                        sda_oe <= 1'b1;
                    end else begin
                        ack_on  <= 1'b0;
                        bit_cnt <= '0;
                        if (state == ST_ADDR_ACK && is_rd) begin
                            shreg  <= cur_rd;
                            sda_oe <= ~cur_rd[7];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= (state == ST_ADDR_ACK) ? ST_WORD : ST_WDATA;
                        end
                    end
                end
                ST_WORD: if (scl_rise) begin
                    shreg   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        ptr[sel] <= rx_byte[WORD_W-1:0];
                        state    <= ST_WORD_ACK;
                    end
                end
                ST_WDATA: if (scl_rise) begin
                    shreg   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        ptr[sel] <= ptr[sel] + WORD_W'(1);
                        state    <= ST_WDATA_ACK;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    if (bit_cnt == 3'd7) begin
                        sda_oe   <= 1'b0;
                        bit_cnt  <= '0;
                        ptr[sel] <= ptr[sel] + WORD_W'(1);
                        state    <= ST_RD_HACK;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        shreg   <= {shreg[6:0], 1'b0};
                        sda_oe  <= ~shreg[6];
                    end
                end
                ST_RD_HACK: if (scl_rise) begin
                    state <= sda_s ? ST_WAIT : ST_RD_NEXT;
                end
                ST_RD_NEXT: if (scl_fall) begin
                    shreg  <= cur_rd;
                    sda_oe <= ~cur_rd[7];
                    state  <= ST_RDATA;
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = sda_oe;
endmodule

// File: rtl/twm_checker.sv
module twm_checker
    import twm_pkg::*;
#(
    parameter int unsigned DIAG_PROT_END = 96
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              lock_i,
    input state_t            state,
    input logic [MAPS-1:0]   we_vec,
    input logic [WORD_W-1:0] wr_addr
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !sda_oe); // R1

    AST_UNMATCHED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sda_oe); // R3

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec)); // R4

    AST_DIAG_GUARD: assert property (@(posedge clk) disable iff (rst)
        we_vec[MAP_DIAG] |-> (32'(wr_addr) >= DIAG_PROT_END)); // R6

    AST_ID_LOCK: assert property (@(posedge clk) disable iff (rst)
        we_vec[MAP_ID] |-> !lock_i); // R7

    AST_SDA_EDGE_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
endmodule

bind dual_map_i2c_target twm_checker #(.DIAG_PROT_END(DIAG_PROT_END)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe),
    .lock_i  (lock_i),
    .state   (state),
    .we_vec  (we_vec),
    .wr_addr (wr_addr)
);

// File: tb/sim_dual_map_i2c_target.sv
module sim_dual_map_i2c_target;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic lock = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic done = 1'b0;

    assign sda_line = host_sda & ~sda_oe;
    always #4 clk = ~clk;

    dual_map_i2c_target u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .lock_i   (lock),
        .sda_oe_o (sda_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int hi_changes = 0;
    logic prev_oe = 1'b0;

    logic [7:0] m_id [256];
    logic [7:0] m_dg [256];
    logic [7:0] m_ptr [2];

    // R10: watch for any change of the drive enable while raw SCL is high
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl) hi_changes++;
        prev_oe = sda_oe;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic bit m_blocked(input int map, input int a);
        return (map == 1) ? (a < 96) : lock;
    endfunction

    function automatic logic [7:0] m_rd(input int map, input int a);
        return (map == 1) ? m_dg[a] : m_id[a];
    endfunction

    task automatic m_wr(input int map, input int a, input logic [7:0] d);
        if (!m_blocked(map, a)) begin
            if (map == 1) m_dg[a] = d;
            else m_id[a] = d;
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wq(Q);
        scl = 1'b1;      wq(Q);
        host_sda = 1'b0; wq(Q);
        scl = 1'b0;      wq(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq(Q);
        scl = 1'b1;      wq(Q);
        host_sda = 1'b1; wq(Q);
    endtask

    task automatic wr_bit(input logic b);
        host_sda = b; wq(Q);
        scl = 1'b1;   wq(2 * Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic rd_bit(output logic b);
        host_sda = 1'b1; wq(Q);
        scl = 1'b1;      wq(Q);
        b = sda_line;    wq(Q);
        scl = 1'b0;      wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            d[i] = b;
        end
        wr_bit(ack ? 1'b0 : 1'b1);
    endtask

    function automatic logic [7:0] dev_byte(input int map, input bit rd);
        return 8'hA0 | 8'(map * 2) | {7'b0, rd};
    endfunction

    task automatic wr_seq(input int map, input int addr, input int n,
                          input logic [7:0] base, input string req);
        logic ak;
        bus_start();
        send_byte(dev_byte(map, 1'b0), ak);
        check(ak, "R2", "device ACK on write", ak, 1);
        send_byte(8'(addr), ak);
        check(ak, "R4", "word address ACK", ak, 1);
        m_ptr[map] = 8'(addr);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = base + 8'(i * 29);
            send_byte(d, ak);
            check(ak, req, "data byte ACK", ak, 1);
            m_wr(map, m_ptr[map], d);
            m_ptr[map] = m_ptr[map] + 8'd1;
        end
        bus_stop();
    endtask

    task automatic rd_body(input int map, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] got;
            logic [7:0] exp;
            exp = m_rd(map, m_ptr[map]);
            recv_byte(i != n - 1, got);
            check(got === exp, req, $sformatf("map%0d byte @%0h", map, m_ptr[map]), got, exp);
            m_ptr[map] = m_ptr[map] + 8'd1;
        end
        bus_stop();
    endtask

    task automatic rd_random(input int map, input int addr, input int n, input string req);
        logic ak;
        bus_start();
        send_byte(dev_byte(map, 1'b0), ak);
        check(ak, "R9", "device ACK before pointer set", ak, 1);
        send_byte(8'(addr), ak);
        check(ak, "R9", "pointer byte ACK", ak, 1);
        m_ptr[map] = 8'(addr);
        bus_start();
        send_byte(dev_byte(map, 1'b1), ak);
        check(ak, "R9", "device ACK after repeated START", ak, 1);
        rd_body(map, n, req);
    endtask

    task automatic rd_current(input int map, input int n, input string req);
        logic ak;
        bus_start();
        send_byte(dev_byte(map, 1'b1), ak);
        check(ak, "R8", "device ACK on current read", ak, 1);
        rd_body(map, n, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic ak;
        logic b;
        int unsigned sd;
        int all_high;
        sd = $urandom(32'd20240);
        for (int i = 0; i < 256; i++) begin
            m_id[i] = 8'h00;
            m_dg[i] = 8'h00;
        end
        m_ptr[0] = 8'h00;
        m_ptr[1] = 8'h00;
        wq(5);
        rst = 1'b0;
        wq(3);

        // R1: released line and zero pointers after reset
        check(sda_oe === 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        wr_seq(0, 0, 1, 8'h9D, "R4");
        rd_current(1, 2, "R1");

        // R2: same location in both maps holds separate data
        wr_seq(0, 8'h70, 1, 8'h12, "R2");
        wr_seq(1, 8'h70, 1, 8'hE7, "R2");
        rd_random(0, 8'h70, 1, "R2");
        rd_random(1, 8'h70, 1, "R2");

        // R3: unmatched device address
        bus_start();
        send_byte(8'hA4, ak);
        check(!ak, "R3", "NACK for 0x52 write", ak, 0);
        send_byte(8'h00, ak);
        check(!ak, "R3", "no ACK after unmatched address", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA7, ak);
        check(!ak, "R3", "NACK for 0x53 read", ak, 0);
        all_high = 1;
        for (int i = 0; i < 8; i++) begin
            rd_bit(b);
            if (b !== 1'b1) all_high = 0;
        end
        check(all_high == 1, "R3", "line released after NACK", all_high, 1);
        bus_stop();

        // R4 / R9: burst write then random read
        wr_seq(0, 8'h20, 5, 8'h5A, "R4");
        rd_random(0, 8'h20, 5, "R9");

        // R5: wrap 255 -> 0 on write and read
        wr_seq(0, 8'hFD, 5, 8'hC1, "R5");
        rd_random(0, 8'hFD, 5, "R5");
        rd_random(1, 8'hFF, 2, "R5");

        // R6: writes across the 95/96 boundary of the diagnostic map
        wr_seq(1, 93, 6, 8'h11, "R6");
        rd_random(1, 93, 6, "R6");

        // R8: per-map current pointers
        rd_random(0, 8'h20, 2, "R8");
        rd_random(1, 8'h60, 1, "R8");
        rd_current(0, 2, "R8");
        rd_current(1, 1, "R8");

        // R10: host NACK leaves the line released until STOP
        bus_start();
        send_byte(dev_byte(0, 1'b1), ak);
        check(ak, "R10", "device ACK before NACKed read", ak, 1);
        begin
            logic [7:0] got;
            logic [7:0] exp;
            exp = m_rd(0, m_ptr[0]);
            recv_byte(1'b0, got);
            check(got === exp, "R10", "MSB-first byte before NACK", got, exp);
            m_ptr[0] = m_ptr[0] + 8'd1;
        end
        all_high = 1;
        for (int i = 0; i < 9; i++) begin
            rd_bit(b);
            if (b !== 1'b1) all_high = 0;
        end
        check(all_high == 1, "R10", "line released after host NACK", all_high, 1);
        bus_stop();

        // R7: lock protects the identification map
        lock = 1'b1;
        wr_seq(0, 8'h20, 2, 8'hEE, "R7");
        rd_random(0, 8'h20, 2, "R7");
        lock = 1'b0;
        wr_seq(0, 8'h21, 1, 8'h44, "R7");
        rd_random(0, 8'h21, 1, "R7");

        // Constrained random mix
        for (int t = 0; t < 25; t++) begin
            int map;
            int addr;
            int n;
            int kind;
            map  = int'($urandom_range(1, 0));
            addr = int'($urandom_range(255, 0));
            n    = int'($urandom_range(4, 1));
            kind = int'($urandom_range(2, 0));
            if (kind == 0) begin
                lock = 1'($urandom_range(1, 0));
                wr_seq(map, addr, n, 8'($urandom_range(255, 0)), map == 1 ? "R6" : "R7");
                lock = 1'b0;
            end else if (kind == 1) begin
                rd_random(map, addr, n, "R9");
            end else begin
                rd_current(map, n, "R8");
            end
        end

        check(hi_changes == 0, "R10", "sda_oe changes while SCL high", hi_changes, 0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule